// File: doc/BRIEF.md
# Address-Space-Tagged Translation Buffer

This block is a small fully associative cache of page translations. Each slot maps a virtual page number to a physical page number. It also stores an address-space number, a global flag that lets the entry match any space, per-privilege-mode read and write enables, and two fault-on-access bits. A requester presents a page number and its current space number. In the same cycle the block returns whether a usable translation exists, along with that translation's physical page and permission bits.

New translations are written through an insert port. The slot written is chosen by a rotating next-slot pointer. Three maintenance commands remove entries:
- drop every entry;
- drop every entry that is not global;
- drop the entries for one page as seen from one address space.

Page-table walking, fault generation and event counting are left to the surrounding logic.

Top module: `asid_tlb`

## Requirements
- R1: A lookup hits when some slot is valid, its tag equals `lk_vpn`, and either its global flag is set or its stored space equals `lk_space`. On a hit, `lk_ppn`, `lk_rd_en`, `lk_wr_en`, `lk_rd_fault` and `lk_wr_fault` carry that slot's stored values.
- R2: A lookup misses when a slot matches only in tag but is non-global and holds a different space, when the tag differs, or when the slot is invalid.
- R3: When several slots match a lookup, the one with the lowest slot index supplies the outputs.
- R4: An insert writes the slot named by the next-slot pointer and overwrites any valid entry already there. The pointer then advances by one and wraps from ENTRIES-1 to 0. After ENTRIES+1 inserts following reset, the first inserted entry is gone and the others remain.
- R5: Command code 2'b01 (flush all) invalidates every slot at the next clock edge.
- R6: Command code 2'b10 (flush private) invalidates every non-global slot and leaves global slots valid.
- R7: Command code 2'b11 (flush page) invalidates every valid slot whose tag equals `cmd_vpn` and that is either global or holds space `cmd_space`. Other slots stay valid. Code 2'b00 does nothing.
- R8: A synchronous reset invalidates every slot and returns the pointer to slot 0.
- R9: When a command and an insert arrive in the same cycle, the command is applied first and the inserted entry is valid afterwards.
- R10: On a miss, `lk_ppn` and all permission and fault outputs are zero.
- R11: Lookup is combinational. An insert or command is visible to lookups starting the cycle after the clock edge that takes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| lk_vpn | input | VPN_W | Lookup virtual page number |
| lk_space | input | SPACE_W | Requester's address-space number |
| lk_hit | output | 1 | Lookup found a usable entry |
| lk_ppn | output | PPN_W | Physical page of the selected entry |
| lk_rd_en | output | MODES | Per-mode read enables of the selected entry |
| lk_wr_en | output | MODES | Per-mode write enables of the selected entry |
| lk_rd_fault | output | 1 | Fault-on-read bit of the selected entry |
| lk_wr_fault | output | 1 | Fault-on-write bit of the selected entry |
| ins_valid | input | 1 | Write a new entry this cycle |
| ins_vpn | input | VPN_W | Tag of the new entry |
| ins_space | input | SPACE_W | Space number of the new entry |
| ins_global | input | 1 | New entry matches every space |
| ins_ppn | input | PPN_W | Physical page of the new entry |
| ins_rd_en | input | MODES | Read enables of the new entry |
| ins_wr_en | input | MODES | Write enables of the new entry |
| ins_rd_fault | input | 1 | Fault-on-read bit of the new entry |
| ins_wr_fault | input | 1 | Fault-on-write bit of the new entry |
| cmd | input | 2 | 00 none, 01 flush all, 10 flush private, 11 flush page |
| cmd_vpn | input | VPN_W | Page number for flush page |
| cmd_space | input | SPACE_W | Space number for flush page |

## Verification
The assertions assume `rst` is held for at least two clock edges at start-up, so the occupancy history they compare against is already clean. They also assume the flush checks apply only in cycles with no insert, which the properties encode with a guard on `ins_valid`. The stimulus keeps page and space numbers in a narrow range so that tag collisions, duplicate entries and cross-space misses occur often. It asserts reset for several cycles before any traffic and places overlapping command-plus-insert cycles only where R9 is being exercised, or at random among the other cycles.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

    typedef enum logic [1:0] {
        CMD_NONE  = 2'b00,
        CMD_ALL   = 2'b01,
        CMD_PRIV  = 2'b10,
        CMD_PAGE  = 2'b11
    } tlb_cmd_e;

endpackage

// File: rtl/tlb_match.sv
// Parallel tag/space comparator: one match line per slot.
module tlb_match #(
    parameter int ENTRIES = 8,
    parameter int VPN_W   = 20,
    parameter int SPACE_W = 8
) (
    input  logic [VPN_W-1:0]   key_vpn,
    input  logic [SPACE_W-1:0] key_space,
    input  logic [ENTRIES-1:0] slot_valid,
    input  logic [ENTRIES-1:0] slot_global,
    input  logic [VPN_W-1:0]   slot_tag   [ENTRIES],
    input  logic [SPACE_W-1:0] slot_space [ENTRIES],
    output logic [ENTRIES-1:0] match
);

    for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
        logic tag_eq;
        logic space_ok;
        assign tag_eq   = (slot_tag[i] == key_vpn);
        assign space_ok = slot_global[i] | (slot_space[i] == key_space);
        assign match[i] = slot_valid[i] & tag_eq & space_ok;
    end

endmodule

// File: rtl/tlb_select.sv
// Lowest-index priority pick over the match lines, with zeroed miss payload.
module tlb_select #(
    parameter int ENTRIES = 8,
    parameter int PAY_W   = 26
) (
    input  logic [ENTRIES-1:0] match,
    input  logic [PAY_W-1:0]   slot_pay [ENTRIES],
    output logic               hit,
    output logic [PAY_W-1:0]   pay
);

    always_comb begin
        hit = 1'b0;
        pay = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (match[i]) begin
                hit = 1'b1;
                pay = slot_pay[i];
            end
        end
    end

endmodule

// File: rtl/tlb_store.sv
// Entry storage and next-slot pointer, two-process style.
module tlb_store
    import tlb_pkg::*;
#(
    parameter int ENTRIES = 8,
    parameter int VPN_W   = 20,
    parameter int SPACE_W = 8,
    parameter int PAY_W   = 26
) (
    input  logic               clk,
    input  logic               rst,
    input  tlb_cmd_e           cmd,
    input  logic [ENTRIES-1:0] page_match,
    input  logic               ins_valid,
    input  logic [VPN_W-1:0]   ins_vpn,
    input  logic [SPACE_W-1:0] ins_space,
    input  logic               ins_global,
    input  logic [PAY_W-1:0]   ins_pay,
    output logic [ENTRIES-1:0] slot_valid,
    output logic [ENTRIES-1:0] slot_global,
    output logic [VPN_W-1:0]   slot_tag   [ENTRIES],
    output logic [SPACE_W-1:0] slot_space [ENTRIES],
    output logic [PAY_W-1:0]   slot_pay   [ENTRIES]
);

    localparam int PTR_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
    localparam logic [PTR_W-1:0] LAST = PTR_W'(ENTRIES - 1);

    typedef struct packed {
        logic               v;
        logic               g;
        logic [SPACE_W-1:0] sp;
        logic [VPN_W-1:0]   tag;
        logic [PAY_W-1:0]   pay;
    } ent_t;

    typedef struct packed {
        ent_t [ENTRIES-1:0] ent;
        logic [PTR_W-1:0]   ptr;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // maintenance command acts first
        for (int i = 0; i < ENTRIES; i++) begin
            unique case (cmd)
                CMD_ALL:  st_d.ent[i].v = 1'b0;
                CMD_PRIV: if (!st_q.ent[i].g) st_d.ent[i].v = 1'b0;
                CMD_PAGE: if (page_match[i]) st_d.ent[i].v = 1'b0;
                default:  ;
            endcase
        end
        // insertion lands on top of the flushed image
        if (ins_valid) begin
            st_d.ent[st_q.ptr].v   = 1'b1;
            st_d.ent[st_q.ptr].g   = ins_global;
            st_d.ent[st_q.ptr].sp  = ins_space;
            st_d.ent[st_q.ptr].tag = ins_vpn;
            st_d.ent[st_q.ptr].pay = ins_pay;
            st_d.ptr = (st_q.ptr == LAST) ? '0 : st_q.ptr + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    for (genvar i = 0; i < ENTRIES; i++) begin : g_out
        assign slot_valid[i]  = st_q.ent[i].v;
        assign slot_global[i] = st_q.ent[i].g;
        assign slot_tag[i]    = st_q.ent[i].tag;
        assign slot_space[i]  = st_q.ent[i].sp;
        assign slot_pay[i]    = st_q.ent[i].pay;
    end

endmodule

// File: rtl/asid_tlb.sv
module asid_tlb
    import tlb_pkg::*;
#(
    parameter int ENTRIES = 8,
    parameter int VPN_W   = 20,
    parameter int PPN_W   = 16,
    parameter int SPACE_W = 8,
    parameter int MODES   = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [VPN_W-1:0]   lk_vpn,
    input  logic [SPACE_W-1:0] lk_space,
    output logic               lk_hit,
    output logic [PPN_W-1:0]   lk_ppn,
    output logic [MODES-1:0]   lk_rd_en,
    output logic [MODES-1:0]   lk_wr_en,
    output logic               lk_rd_fault,
    output logic               lk_wr_fault,
    input  logic               ins_valid,
    input  logic [VPN_W-1:0]   ins_vpn,
    input  logic [SPACE_W-1:0] ins_space,
    input  logic               ins_global,
    input  logic [PPN_W-1:0]   ins_ppn,
    input  logic [MODES-1:0]   ins_rd_en,
    input  logic [MODES-1:0]   ins_wr_en,
    input  logic               ins_rd_fault,
    input  logic               ins_wr_fault,
    input  logic [1:0]         cmd,
    input  logic [VPN_W-1:0]   cmd_vpn,
    input  logic [SPACE_W-1:0] cmd_space
);

    localparam int PAY_W = PPN_W + 2 * MODES + 2;

    logic [ENTRIES-1:0] entry_valid;
    logic [ENTRIES-1:0] slot_global;
    logic [VPN_W-1:0]   slot_tag   [ENTRIES];
    logic [SPACE_W-1:0] slot_space [ENTRIES];
    logic [PAY_W-1:0]   slot_pay   [ENTRIES];
    logic [ENTRIES-1:0] lk_match;
    logic [ENTRIES-1:0] page_match;
    logic [PAY_W-1:0]   ins_pay;
    logic [PAY_W-1:0]   sel_pay;

    assign ins_pay = {ins_ppn, ins_rd_en, ins_wr_en, ins_rd_fault, ins_wr_fault};

    tlb_store #(
        .ENTRIES(ENTRIES), .VPN_W(VPN_W), .SPACE_W(SPACE_W), .PAY_W(PAY_W)
    ) u_store (
        .clk        (clk),
        .rst        (rst),
        .cmd        (tlb_cmd_e'(cmd)),
        .page_match (page_match),
        .ins_valid  (ins_valid),
        .ins_vpn    (ins_vpn),
        .ins_space  (ins_space),
        .ins_global (ins_global),
        .ins_pay    (ins_pay),
        .slot_valid (entry_valid),
        .slot_global(slot_global),
        .slot_tag   (slot_tag),
        .slot_space (slot_space),
        .slot_pay   (slot_pay)
    );

    // comparator for the lookup port
    tlb_match #(
        .ENTRIES(ENTRIES), .VPN_W(VPN_W), .SPACE_W(SPACE_W)
    ) u_lk_match (
        .key_vpn    (lk_vpn),
        .key_space  (lk_space),
        .slot_valid (entry_valid),
        .slot_global(slot_global),
        .slot_tag   (slot_tag),
        .slot_space (slot_space),
        .match      (lk_match)
    );

    // second comparator bank serves the single-page flush
    tlb_match #(
        .ENTRIES(ENTRIES), .VPN_W(VPN_W), .SPACE_W(SPACE_W)
    ) u_pg_match (
        .key_vpn    (cmd_vpn),
        .key_space  (cmd_space),
        .slot_valid (entry_valid),
        .slot_global(slot_global),
        .slot_tag   (slot_tag),
        .slot_space (slot_space),
        .match      (page_match)
    );

    tlb_select #(
        .ENTRIES(ENTRIES), .PAY_W(PAY_W)
    ) u_select (
        .match   (lk_match),
        .slot_pay(slot_pay),
        .hit     (lk_hit),
        .pay     (sel_pay)
    );

    assign {lk_ppn, lk_rd_en, lk_wr_en, lk_rd_fault, lk_wr_fault} = sel_pay;

endmodule

// File: rtl/asid_tlb_chk.sv
module asid_tlb_chk #(
    parameter int ENTRIES = 8,
    parameter int PPN_W   = 16,
    parameter int MODES   = 4
) (
    input logic               clk,
    input logic               rst,
    input logic [1:0]         cmd,
    input logic               ins_valid,
    input logic               lk_hit,
    input logic [PPN_W-1:0]   lk_ppn,
    input logic [MODES-1:0]   lk_rd_en,
    input logic [MODES-1:0]   lk_wr_en,
    input logic               lk_rd_fault,
    input logic               lk_wr_fault,
    input logic [ENTRIES-1:0] entry_valid
);

    // R10
    miss_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !lk_hit |-> (lk_ppn == '0 && lk_rd_en == '0 && lk_wr_en == '0
                     && !lk_rd_fault && !lk_wr_fault));

    // R1
    hit_needs_entry_chk: assert property (@(posedge clk) disable iff (rst)
        lk_hit |-> (entry_valid != '0));

    // R5
    flush_all_empty_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd == 2'b01 && !ins_valid) |=> (entry_valid == '0));

    // R6
    flush_priv_shrink_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd == 2'b10 && !ins_valid) |=>
            ($countones(entry_valid) <= $countones($past(entry_valid))));

    // R7
    flush_page_shrink_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd == 2'b11 && !ins_valid) |=>
            ($countones(entry_valid) <= $countones($past(entry_valid))));

    // R4
    insert_grow_one_chk: assert property (@(posedge clk) disable iff (rst)
        ins_valid |=>
            ($countones(entry_valid) <= $countones($past(entry_valid)) + 1));

    // R9
    insert_lands_chk: assert property (@(posedge clk) disable iff (rst)
        ins_valid |=> (entry_valid != '0));

endmodule

bind asid_tlb asid_tlb_chk #(
    .ENTRIES(ENTRIES), .PPN_W(PPN_W), .MODES(MODES)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .cmd        (cmd),
    .ins_valid  (ins_valid),
    .lk_hit     (lk_hit),
    .lk_ppn     (lk_ppn),
    .lk_rd_en   (lk_rd_en),
    .lk_wr_en   (lk_wr_en),
    .lk_rd_fault(lk_rd_fault),
    .lk_wr_fault(lk_wr_fault),
    .entry_valid(entry_valid)
);

// File: tb/asid_tlb_bench.sv
`timescale 1ns/1ps
module asid_tlb_bench;

    localparam int ENTRIES = 8;
    localparam int VPN_W   = 20;
    localparam int PPN_W   = 16;
    localparam int SPACE_W = 8;
    localparam int MODES   = 4;
    localparam int PAY_W   = PPN_W + 2 * MODES + 2;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic [VPN_W-1:0]   lk_vpn = '0;
    logic [SPACE_W-1:0] lk_space = '0;
    logic               lk_hit;
    logic [PPN_W-1:0]   lk_ppn;
    logic [MODES-1:0]   lk_rd_en, lk_wr_en;
    logic               lk_rd_fault, lk_wr_fault;
    logic               ins_valid = 1'b0;
    logic [VPN_W-1:0]   ins_vpn = '0;
    logic [SPACE_W-1:0] ins_space = '0;
    logic               ins_global = 1'b0;
    logic [PPN_W-1:0]   ins_ppn = '0;
    logic [MODES-1:0]   ins_rd_en = '0, ins_wr_en = '0;
    logic               ins_rd_fault = 1'b0, ins_wr_fault = 1'b0;
    logic [1:0]         cmd = 2'b00;
    logic [VPN_W-1:0]   cmd_vpn = '0;
    logic [SPACE_W-1:0] cmd_space = '0;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    asid_tlb #(
        .ENTRIES(ENTRIES), .VPN_W(VPN_W), .PPN_W(PPN_W),
        .SPACE_W(SPACE_W), .MODES(MODES)
    ) u_asid_tlb (.*);

    // reference model
    bit               m_v   [ENTRIES];
    bit               m_g   [ENTRIES];
    logic [VPN_W-1:0] m_tag [ENTRIES];
    logic [SPACE_W-1:0] m_sp [ENTRIES];
    logic [PAY_W-1:0] m_pay [ENTRIES];
    int               m_ptr = 0;

    function automatic bit ent_match(int i, logic [VPN_W-1:0] v, logic [SPACE_W-1:0] s);
        return m_v[i] && m_tag[i] == v && (m_g[i] || m_sp[i] == s);
    endfunction

    function automatic logic [PAY_W:0] model_lookup(logic [VPN_W-1:0] v, logic [SPACE_W-1:0] s);
        for (int i = 0; i < ENTRIES; i++)
            if (ent_match(i, v, s)) return {1'b1, m_pay[i]};
        return '0;
    endfunction

    task automatic model_reset();
        for (int i = 0; i < ENTRIES; i++) m_v[i] = 1'b0;
        m_ptr = 0;
    endtask

    task automatic model_edge();
        for (int i = 0; i < ENTRIES; i++) begin
            case (cmd)
                2'b01: m_v[i] = 1'b0;
                2'b10: if (!m_g[i]) m_v[i] = 1'b0;
                2'b11: if (ent_match(i, cmd_vpn, cmd_space)) m_v[i] = 1'b0;
                default: ;
            endcase
        end
        if (ins_valid) begin
            m_v[m_ptr]   = 1'b1;
            m_g[m_ptr]   = ins_global;
            m_tag[m_ptr] = ins_vpn;
            m_sp[m_ptr]  = ins_space;
            m_pay[m_ptr] = {ins_ppn, ins_rd_en, ins_wr_en, ins_rd_fault, ins_wr_fault};
            m_ptr = (m_ptr == ENTRIES - 1) ? 0 : m_ptr + 1;
        end
    endtask

    // one clock: inputs already driven after a falling edge
    task automatic step();
        @(posedge clk);
        if (rst) model_reset(); else model_edge();
        @(negedge clk);
        ins_valid = 1'b0;
        cmd = 2'b00;
    endtask

    task automatic do_insert(int v, int s, bit g, int p);
        ins_valid = 1'b1;
        ins_vpn = VPN_W'(v);
        ins_space = SPACE_W'(s);
        ins_global = g;
        ins_ppn = PPN_W'(p);
        ins_rd_en = MODES'(p);
        ins_wr_en = MODES'(p >> 2);
        ins_rd_fault = p[0];
        ins_wr_fault = p[1];
        step();
    endtask

    task automatic do_cmd(logic [1:0] c, int v, int s);
        cmd = c;
        cmd_vpn = VPN_W'(v);
        cmd_space = SPACE_W'(s);
        step();
    endtask

    task automatic check_lookup(int v, int s, string req);
        logic [PAY_W:0] exp_r, got;
        lk_vpn = VPN_W'(v);
        lk_space = SPACE_W'(s);
        #2;
        exp_r = model_lookup(lk_vpn, lk_space);
        got = {lk_hit, lk_ppn, lk_rd_en, lk_wr_en, lk_rd_fault, lk_wr_fault};
        checks++;
        if (got !== exp_r) begin
            failures++;
            $display("FAIL %s vpn=%0d space=%0d actual=%h expected=%h", req, v, s, got, exp_r);
        end
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        @(negedge clk);
        rst = 1'b1;
        step(); step(); step();
        rst = 1'b0;

        // R8: empty after reset, R10 zero outputs on miss
        check_lookup(0, 0, "R8");
        check_lookup(1, 0, "R10");

        // R11, R1: insert visible next cycle
        do_insert(5, 1, 1'b0, 16'h1234);
        check_lookup(5, 1, "R11");
        // R2: same tag other space misses; other tag misses
        check_lookup(5, 2, "R2");
        check_lookup(6, 1, "R2");
        // R1: global entry matches any space
        do_insert(7, 3, 1'b1, 16'h0abc);
        check_lookup(7, 9, "R1");
        // R3: duplicate global tag, lowest slot wins
        do_insert(7, 4, 1'b1, 16'h0555);
        check_lookup(7, 4, "R3");
        // R7: flush page for space 1 removes vpn 5 only
        do_cmd(2'b11, 5, 1);
        check_lookup(5, 1, "R7");
        check_lookup(7, 0, "R7");
        // R7: flush page for global tag from any space removes both copies
        do_cmd(2'b11, 7, 6);
        check_lookup(7, 4, "R7");
        // R7: code 00 does nothing
        do_insert(2, 2, 1'b0, 16'h0222);
        do_cmd(2'b00, 2, 2);
        check_lookup(2, 2, "R7");
        // R6: flush private keeps global
        do_insert(3, 2, 1'b1, 16'h0333);
        do_cmd(2'b10, 0, 0);
        check_lookup(2, 2, "R6");
        check_lookup(3, 0, "R6");
        // R5: flush all
        do_cmd(2'b01, 0, 0);
        check_lookup(3, 0, "R5");
        // R9: flush all with insert same cycle
        cmd = 2'b01;
        do_insert(9, 1, 1'b0, 16'h0999);
        check_lookup(9, 1, "R9");
        // R4: wrap: ENTRIES+1 inserts after reset
        rst = 1'b1;
        step(); step();
        rst = 1'b0;
        for (int i = 0; i <= ENTRIES; i++) do_insert(100 + i, 0, 1'b0, 16'h100 + i);
        check_lookup(100, 0, "R4");
        check_lookup(101, 0, "R4");
        check_lookup(100 + ENTRIES, 0, "R4");

        // random traffic
        for (int n = 0; n < 3000; n++) begin
            int r;
            r = int'($urandom % 64);
            if (r < 36) begin
                if (r < 3) cmd = 2'(($urandom % 3) + 1);
                cmd_vpn = VPN_W'($urandom % 6);
                cmd_space = SPACE_W'($urandom % 3);
                do_insert(int'($urandom % 6), int'($urandom % 3),
                          ($urandom % 4) == 0, int'($urandom % 65536));
            end else if (r < 50) begin
                do_cmd(2'b11, int'($urandom % 6), int'($urandom % 3));
            end else if (r < 56) begin
                do_cmd(2'b10, 0, 0);
            end else if (r < 57) begin
                do_cmd(2'b01, 0, 0);
            end else begin
                step();
            end
            for (int k = 0; k < 2; k++)
                check_lookup(int'($urandom % 7), int'($urandom % 3), "R1");
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule